// File: doc/BRIEF.md
# Edge-Kicked Latching Watchdog Timer

This block supervises a processor by watching one strobe line. Every change of level on the strobe, rising or falling, counts as a kick and restarts a window whose length in clock ticks comes from a runtime input. If a whole window passes with no kick, the block pulls its active-low fault output low. The fault then stays low until a later kick or until the supervisor reset clears it.

The supervisor reset arrives as an active-low level input. While it is low, the timer is idle and the fault output is held high. Edges on the strobe during that time are discarded. Releasing the reset starts a fresh full window.

The strobe is asynchronous to the clock, so it passes through two flops before edge detection.

Top module: `strobe_watchdog`

## Requirements
- R1: A rising or a falling level change on `strobe_in` is a kick. It takes effect at the third rising clock edge after the change: two edges for synchronization and one for the registered result.
- R2: If no kick arrives, `fault_n` goes low at the W-th rising edge after the window starts. W is `window_ticks`. A window starts at a kick edge or at the last edge with supervisor reset asserted.
- R3: Once low, `fault_n` stays low for as long as no kick arrives and the supervisor reset stays released.
- R4: A kick while `fault_n` is low drives it high at the kick edge and starts a new full window of W ticks.
- R5: While `sup_rst_n` is 0, `fault_n` is 1, and strobe edges seen during that time cause no later effect.
- R6: After `sup_rst_n` returns to 1, a full window of W ticks passes before `fault_n` can go low.
- R7: A strobe pulse held for a single clock period is detected. Its leading edge takes effect at the third edge after the pulse begins.
- R8: A `window_ticks` value of 0 behaves exactly as a value of 1.
- R9: When a kick and a window expiry fall on the same clock edge, the kick wins: `fault_n` stays high and a new window starts.
- R10: While `arst_n` is 0, `fault_n` is 1 and the timer and synchronizer are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous clear, active low |
| strobe_in | input | 1 | Asynchronous strobe from the processor; any edge is a kick |
| sup_rst_n | input | 1 | Supervisor reset level, active low, synchronous to clk |
| window_ticks | input | TICK_W | Window length in clock ticks; 0 counts as 1 |
| fault_n | output | 1 | Watchdog fault, active low, latching |

## Verification
The results arrive at fixed times after their stimulus:
- A strobe change clears the fault three rising edges after it is driven.
- An expiry shows W edges after the window-start edge.
- Both supervisor reset and its release act at the next edge.

The bench drives every input on the falling edge and samples `fault_n` at the falling edge after each rising edge. It checks the expected level on every cycle of each window, so an early or late change is caught at the exact edge. The window length is swept from 0 to 6. The same-cycle race is staged by timing a strobe change so that its kick lands on the expiry edge.

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              strobe_in,
  input  logic              sup_rst_n,
  input  logic [TICK_W-1:0] window_ticks,
  output logic              fault_n
);

  logic [2:0]        smp;
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] last_tick;
  logic              kick;
  logic              expire;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) smp <= '0;
    else         smp <= {smp[1:0], strobe_in};

  assign kick      = smp[2] ^ smp[1];
  assign last_tick = (window_ticks == '0) ? '0 : window_ticks - 1'b1;
  assign expire    = (cnt >= last_tick);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      cnt     <= '0;
      fault_n <= 1'b1;
    end else if (!sup_rst_n || kick) begin
      cnt     <= '0;
      fault_n <= 1'b1;
    end else if (fault_n) begin
      if (expire) fault_n <= 1'b0;
      else        cnt     <= cnt + 1'b1;
    end

  a_r5_reset_holds_high: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_rst_n |=> fault_n);

  a_r4_kick_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (sup_rst_n && kick) |=> fault_n);

  a_r3_fault_latches: assert property (@(posedge clk) disable iff (!arst_n)
    (sup_rst_n && !kick && !fault_n) |=> !fault_n);

  a_r2_fall_needs_expiry: assert property (@(posedge clk) disable iff (!arst_n)
    (sup_rst_n && !kick && fault_n && !expire) |=> fault_n);

  a_r9_kick_beats_expiry: assert property (@(posedge clk) disable iff (!arst_n)
    (sup_rst_n && kick && expire) |=> (fault_n && cnt == '0));

endmodule

// File: tb/test_strobe_watchdog.sv
module test_strobe_watchdog;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       strobe_in;
  logic       sup_rst_n;
  logic [7:0] window_ticks;
  logic       fault_n;
  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  strobe_watchdog #(.TICK_W(8)) i_strobe_watchdog (
    .clk(clk), .arst_n(arst_n), .strobe_in(strobe_in), .sup_rst_n(sup_rst_n),
    .window_ticks(window_ticks), .fault_n(fault_n));

  task automatic chk(input logic exp, input string req);
    nchk++;
    if (fault_n !== exp) begin
      nerr++;
      $display("FAIL %s: fault_n=%b expected %b at %0t", req, fault_n, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; sup_rst_n = 1'b0; strobe_in = 1'b0; window_ticks = 8'd0;
    repeat (3) @(negedge clk);
    chk(1'b1, "R10");
    arst_n = 1'b1;
    for (int w = 0; w <= 6; w++) begin
      int lim;
      lim = (w == 0) ? 1 : w;
      window_ticks = w[7:0];
      sup_rst_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
        strobe_in = ~strobe_in;
        step();
        chk(1'b1, "R5");
      end
      repeat (4) begin step(); chk(1'b1, "R5"); end
      sup_rst_n = 1'b1;
      // R6 / R8: full window after release, W=0 acting as 1
      for (int k = 1; k <= lim; k++) begin
        step();
        chk((k < lim) ? 1'b1 : 1'b0, (w == 0) ? "R8" : "R6");
      end
      repeat (5) begin step(); chk(1'b0, "R3"); end
      // R1: kick effective at third edge
      strobe_in = ~strobe_in;
      for (int k = 1; k <= 3; k++) begin
        step();
        chk((k < 3) ? 1'b0 : 1'b1, "R1");
      end
      // R4 / R2: fresh window after the clearing kick
      for (int k = 1; k <= lim; k++) begin
        step();
        chk((k < lim) ? 1'b1 : 1'b0, "R4");
      end
      // R7: one-cycle pulse gives two kicks
      strobe_in = ~strobe_in;
      step(); chk(1'b0, "R7");
      strobe_in = ~strobe_in;
      step(); chk(1'b0, "R7");
      step(); chk(1'b1, "R7");
      for (int k = 1; k <= lim + 1; k++) begin
        step();
        chk((k <= lim) ? 1'b1 : 1'b0, "R2");
      end
      // R9: kick lands on the expiry edge
      if (lim >= 3) begin
        strobe_in = ~strobe_in;
        for (int k = 1; k <= 3; k++) begin
          step();
          chk((k < 3) ? 1'b0 : 1'b1, "R1");
        end
        for (int k = 1; k <= lim - 3; k++) begin
          step(); chk(1'b1, "R9");
        end
        strobe_in = ~strobe_in;
        for (int k = 1; k <= 3; k++) begin
          step(); chk(1'b1, "R9");
        end
        for (int k = 1; k <= lim; k++) begin
          step();
          chk((k < lim) ? 1'b1 : 1'b0, "R9");
        end
      end
    end
    arst_n = 1'b0;
    step();
    chk(1'b1, "R10");
    finish_run();
  end
endmodule